// File: doc/BRIEF.md
# Serial Port Control and Status Front End

This block is the register and interrupt front end of a FIFO-based asynchronous serial port. A CPU writes and reads six byte-wide registers through a simple write strobe, address and data interface: frame mode, bit-rate divisor, control, status flags, FIFO control and line status. The block drops reserved bits on each write. It gives status flags their write-zero-to-clear behaviour. It forms four level interrupt requests (transmit, receive, receive error, break) from those flags and the enable bits.

On the FIFO side, the block takes one-cycle event strobes from the transmit and receive FIFOs and the receiver. These strobes set status flags. The block returns one-cycle FIFO reset pulses, the transmit and receive enables, and the frame-format fields. It also routes the serial data path: in loopback mode the transmit stream feeds the receiver and the outgoing line idles high. A prescaler and an 8-bit divisor produce a frame-tick strobe once per ten-bit character time.

Top module: `serial_ctrl_regs`

## Requirements
- R1: After reset, every register reads 0, except the status register, which reads 0x60 (transmit-end and transmit-empty flags set). All four interrupt requests and both FIFO reset pulses are low.
- R2: Register addresses are: mode 0, bit rate 1, control 2, status 3, FIFO control 4, line status 5. Control writes are masked to 0xFA. Control bit 7 is the transmit interrupt enable, bit 6 the receive interrupt enable, bit 5 the transmit enable (tx_en), bit 4 the receive enable (rx_en), bit 3 the receive-error interrupt enable and bit 1 the external clock enable (ext_clk_en).
- R3: Mode writes are masked to 0x7B. frame_fmt carries {mode[6] seven-bit data, mode[5] parity enable, mode[4] odd parity, mode[3] two stop bits}. mode[1:0] selects a prescale of 1, 4, 16 or 64.
- R4: Status flag positions are: 7 receive error, 6 transmit end, 5 transmit empty, 4 break, 3 framing error, 2 parity error, 1 receive full, 0 data ready. A status write stores the old value AND the written value, so software can clear flags but never set them.
- R5: Flag-setting events win over a software clear of the same flag in the same cycle. ev_rx_ready sets bit 0, ev_rx_full bit 1, ev_parity_err bits 2 and 7, ev_frame_err bits 3 and 7, ev_break bit 4, ev_tx_empty bit 5 and ev_tx_end bit 6.
- R6: irq_tx = control bit 7 AND status bit 5. irq_rx = control bit 6 AND (status bit 1 OR bit 0).
- R7: irq_err and irq_brk are enabled when control bit 6 or bit 3 is set. irq_err asserts on status bit 7 or the overrun bit. irq_brk asserts on status bit 4.
- R8: Requests are levels. A control write that clears an enable drops the matching request in the next cycle, without touching the flags.
- R9: FIFO control keeps bit 3 (modem_ctl_en) and bit 0 (loopback) and reads back only those. Writing bit 2 gives a one-cycle tx_fifo_clr pulse in the following cycle and sets status bits 6 and 5. Writing bit 1 gives a one-cycle rx_fifo_clr pulse and clears status bits 1 and 0, even over a same-cycle receive event.
- R10: Line status bit 0 is the overrun flag. ev_overrun sets it. A write can only clear it (by writing 0 to bit 0). An overrun event in the same cycle as that write wins.
- R11: With loopback set, rx_ser_out follows tx_ser_in and line_tx_out is 1. Otherwise rx_ser_out follows ext_rx_in and line_tx_out follows tx_ser_in.
- R12: While tx_en or rx_en is set, frame_tick pulses for one cycle every 320 × prescale × (rate + 1) clocks. The bit-rate register reads back all 8 bits. Writing mode or rate restarts the count, and the tick stays low while both enables are clear.
- R13: Reads of addresses 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| ev_rx_ready | input | 1 | Receive data-ready event |
| ev_rx_full | input | 1 | Receive FIFO reached its trigger level |
| ev_parity_err | input | 1 | Parity error event |
| ev_frame_err | input | 1 | Framing error event |
| ev_break | input | 1 | Break detected event |
| ev_tx_empty | input | 1 | Transmit FIFO fell to its trigger level |
| ev_tx_end | input | 1 | Transmission ended event |
| ev_overrun | input | 1 | Receive FIFO overrun event |
| tx_fifo_clr | output | 1 | One-cycle transmit FIFO reset |
| rx_fifo_clr | output | 1 | One-cycle receive FIFO reset |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |
| ext_clk_en | output | 1 | External clock select |
| modem_ctl_en | output | 1 | Modem control enable |
| frame_fmt | output | 4 | Seven-bit, parity enable, odd parity, two stop bits |
| frame_tick | output | 1 | One pulse per character time |
| tx_ser_in | input | 1 | Serial stream from the transmitter |
| ext_rx_in | input | 1 | Serial stream from the external line |
| line_tx_out | output | 1 | Serial stream to the external line |
| rx_ser_out | output | 1 | Serial stream to the receiver |
| irq_tx | output | 1 | Transmit interrupt request |
| irq_rx | output | 1 | Receive interrupt request |
| irq_err | output | 1 | Receive-error interrupt request |
| irq_brk | output | 1 | Break interrupt request |

## Verification
The key collision is a software write to the status or line status register in the same cycle as a FIFO or receiver event that sets the flag being cleared. The same applies to a FIFO reset colliding with a receive event. The bench provokes each case by driving the write and the event strobe in one cycle. It then judges the result by reading the register back, and by checking the interrupt lines against a behavioural model that gives events priority over clears and FIFO reset priority over receive events.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int unsigned RW = 8;
  localparam logic [2:0] ADR_MODE  = 3'd0;
  localparam logic [2:0] ADR_RATE  = 3'd1;
  localparam logic [2:0] ADR_CTRL  = 3'd2;
  localparam logic [2:0] ADR_STAT  = 3'd3;
  localparam logic [2:0] ADR_FCTL  = 3'd4;
  localparam logic [2:0] ADR_LSTAT = 3'd5;

  localparam logic [RW-1:0] MODE_MASK  = 8'h7B;
  localparam logic [RW-1:0] CTRL_MASK  = 8'hFA;
  localparam logic [RW-1:0] FCTL_KEEP  = 8'h09;
  localparam logic [RW-1:0] STAT_RESET = 8'h60;
  localparam logic [RW-1:0] TX_CLR_SET = 8'h60;
  localparam logic [RW-1:0] RX_CLR_MSK = 8'h03;

  // control bit positions
  localparam int unsigned C_TIE = 7;
  localparam int unsigned C_RIE = 6;
  localparam int unsigned C_TE  = 5;
  localparam int unsigned C_RE  = 4;
  localparam int unsigned C_EIE = 3;
  localparam int unsigned C_CKE = 1;

  // status bit positions
  localparam int unsigned S_ERR  = 7;
  localparam int unsigned S_TEND = 6;
  localparam int unsigned S_TEMP = 5;
  localparam int unsigned S_BRK  = 4;
  localparam int unsigned S_FER  = 3;
  localparam int unsigned S_PER  = 2;
  localparam int unsigned S_RFUL = 1;
  localparam int unsigned S_RDY  = 0;

  typedef struct packed {
    logic [RW-1:0] mode;
    logic [RW-1:0] rate;
    logic [RW-1:0] ctrl;
    logic [RW-1:0] fctl;
    logic          ovr;
  } cfg_t;
endpackage

// File: rtl/sreg_cfg.sv
module sreg_cfg
  import sreg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [2:0]    addr,
  input  logic [RW-1:0] wdata,
  input  logic          ev_overrun,
  output cfg_t          cfg_q,
  output logic          tx_clr_now,
  output logic          rx_clr_now,
  output logic          restart,
  output logic          tx_fifo_clr,
  output logic          rx_fifo_clr
);
  cfg_t cfg_d;
  logic cfg_en;
  logic wr_mode, wr_rate, wr_ctrl, wr_fctl, wr_lst;

  always_comb begin
    wr_mode = wr && (addr == ADR_MODE);
    wr_rate = wr && (addr == ADR_RATE);
    wr_ctrl = wr && (addr == ADR_CTRL);
    wr_fctl = wr && (addr == ADR_FCTL);
    wr_lst  = wr && (addr == ADR_LSTAT);

    cfg_d      = cfg_q;
    cfg_d.mode = wr_mode ? (wdata & MODE_MASK) : cfg_q.mode;
    cfg_d.rate = wr_rate ? wdata : cfg_q.rate;
    cfg_d.ctrl = wr_ctrl ? (wdata & CTRL_MASK) : cfg_q.ctrl;
    cfg_d.fctl = wr_fctl ? (wdata & FCTL_KEEP) : cfg_q.fctl;
    cfg_d.ovr  = ev_overrun | (cfg_q.ovr & ~(wr_lst & ~wdata[0]));
    cfg_en     = wr | ev_overrun;

    restart    = wr_mode | wr_rate;
    tx_clr_now = wr_fctl & wdata[2];
    rx_clr_now = wr_fctl & wdata[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q       <= '0;
      tx_fifo_clr <= 1'b0;
      rx_fifo_clr <= 1'b0;
    end else begin
      if (cfg_en) cfg_q <= cfg_d;
      tx_fifo_clr <= tx_clr_now;
      rx_fifo_clr <= rx_clr_now;
    end
  end

  // R10
  ovr_no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lst && !ev_overrun) |=> !(cfg_q.ovr && !$past(cfg_q.ovr)));

  // R9
  clr_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fifo_clr && !$past(tx_clr_now, 2)) |=> !tx_fifo_clr);
endmodule

// File: rtl/sreg_status.sv
module sreg_status
  import sreg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stat,
  input  logic [RW-1:0] wdata,
  input  logic [RW-1:0] set_vec,
  input  logic          tx_clr_now,
  input  logic          rx_clr_now,
  output logic [RW-1:0] stat_q
);
  logic [RW-1:0] stat_d;
  logic          stat_en;

  always_comb begin
    stat_d = stat_q;
    if (wr_stat) stat_d = stat_d & wdata;
    stat_d = stat_d | set_vec;
    if (tx_clr_now) stat_d = stat_d | TX_CLR_SET;
    if (rx_clr_now) stat_d = stat_d & ~RX_CLR_MSK;
    stat_en = wr_stat | (|set_vec) | tx_clr_now | rx_clr_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= STAT_RESET;
    else if (stat_en) stat_q <= stat_d;
  end

  // R4
  stat_no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && (set_vec == '0) && !tx_clr_now) |=> ((stat_q & ~$past(stat_q)) == '0));

  // R5
  stat_event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec[S_RFUL] && !rx_clr_now) |=> stat_q[S_RFUL]);
endmodule

// File: rtl/sreg_tick.sv
module sreg_tick #(
  parameter int unsigned OVERSAMPLE = 32,
  parameter int unsigned FRAME_BITS = 10,
  parameter int unsigned RATE_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic [1:0]        cks,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  localparam int unsigned C1W = $clog2(OVERSAMPLE * 64);
  localparam int unsigned C3W = $clog2(FRAME_BITS);

  logic [C1W-1:0]    c1_q, c1_d, c1_top;
  logic [RATE_W-1:0] c2_q, c2_d;
  logic [C3W-1:0]    c3_q, c3_d;
  logic [C1W:0]      div1;
  logic              l1, l2, l3, cnt_en;

  always_comb begin
    div1   = (C1W+1)'(OVERSAMPLE) << {cks, 1'b0};
    c1_top = C1W'(div1 - 1'b1);
    l1     = (c1_q == c1_top);
    l2     = (c2_q == rate);
    l3     = (c3_q == C3W'(FRAME_BITS - 1));
    tick   = run & l1 & l2 & l3;
    cnt_en = 1'b1;
    c1_d = c1_q; c2_d = c2_q; c3_d = c3_q;
    if (restart || !run) begin
      c1_d = '0; c2_d = '0; c3_d = '0;
    end else begin
      c1_d = l1 ? '0 : c1_q + 1'b1;
      if (l1) c2_d = l2 ? '0 : c2_q + 1'b1;
      if (l1 && l2) c3_d = l3 ? '0 : c3_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c1_q <= '0; c2_q <= '0; c3_q <= '0;
    end else if (cnt_en) begin
      c1_q <= c1_d; c2_q <= c2_d; c3_q <= c3_d;
    end
  end

  // R12
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R12
  tick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run || restart) |=> (c1_q == '0));
endmodule

// File: rtl/serial_ctrl_regs.sv
module serial_ctrl_regs
  import sreg_pkg::*;
#(
  parameter int unsigned OVERSAMPLE = 32,
  parameter int unsigned FRAME_BITS = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       ev_rx_ready,
  input  logic       ev_rx_full,
  input  logic       ev_parity_err,
  input  logic       ev_frame_err,
  input  logic       ev_break,
  input  logic       ev_tx_empty,
  input  logic       ev_tx_end,
  input  logic       ev_overrun,
  output logic       tx_fifo_clr,
  output logic       rx_fifo_clr,
  output logic       tx_en,
  output logic       rx_en,
  output logic       ext_clk_en,
  output logic       modem_ctl_en,
  output logic [3:0] frame_fmt,
  output logic       frame_tick,
  input  logic       tx_ser_in,
  input  logic       ext_rx_in,
  output logic       line_tx_out,
  output logic       rx_ser_out,
  output logic       irq_tx,
  output logic       irq_rx,
  output logic       irq_err,
  output logic       irq_brk
);
  cfg_t          cfg;
  logic [RW-1:0] stat, set_vec;
  logic          tx_clr_now, rx_clr_now, restart, err_en, loop;

  sreg_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .ev_overrun(ev_overrun), .cfg_q(cfg), .tx_clr_now(tx_clr_now),
    .rx_clr_now(rx_clr_now), .restart(restart),
    .tx_fifo_clr(tx_fifo_clr), .rx_fifo_clr(rx_fifo_clr)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[S_RDY]  = ev_rx_ready;
    set_vec[S_RFUL] = ev_rx_full;
    set_vec[S_PER]  = ev_parity_err;
    set_vec[S_FER]  = ev_frame_err;
    set_vec[S_BRK]  = ev_break;
    set_vec[S_TEMP] = ev_tx_empty;
    set_vec[S_TEND] = ev_tx_end;
    set_vec[S_ERR]  = ev_parity_err | ev_frame_err;
  end

  sreg_status u_stat (
    .clk(clk), .rst_n(rst_n), .wr_stat(reg_wr && (reg_addr == ADR_STAT)),
    .wdata(reg_wdata), .set_vec(set_vec), .tx_clr_now(tx_clr_now),
    .rx_clr_now(rx_clr_now), .stat_q(stat)
  );

  sreg_tick #(.OVERSAMPLE(OVERSAMPLE), .FRAME_BITS(FRAME_BITS), .RATE_W(RW)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(tx_en | rx_en), .restart(restart),
    .cks(cfg.mode[1:0]), .rate(cfg.rate), .tick(frame_tick)
  );

  always_comb begin
    tx_en        = cfg.ctrl[C_TE];
    rx_en        = cfg.ctrl[C_RE];
    ext_clk_en   = cfg.ctrl[C_CKE];
    modem_ctl_en = cfg.fctl[3];
    loop         = cfg.fctl[0];
    frame_fmt    = cfg.mode[6:3];
    line_tx_out  = loop ? 1'b1 : tx_ser_in;
    rx_ser_out   = loop ? tx_ser_in : ext_rx_in;
    err_en       = cfg.ctrl[C_RIE] | cfg.ctrl[C_EIE];
    irq_tx       = cfg.ctrl[C_TIE] & stat[S_TEMP];
    irq_rx       = cfg.ctrl[C_RIE] & (stat[S_RFUL] | stat[S_RDY]);
    irq_err      = err_en & (stat[S_ERR] | cfg.ovr);
    irq_brk      = err_en & stat[S_BRK];
    case (reg_addr)
      ADR_MODE:  reg_rdata = cfg.mode;
      ADR_RATE:  reg_rdata = cfg.rate;
      ADR_CTRL:  reg_rdata = cfg.ctrl;
      ADR_STAT:  reg_rdata = stat;
      ADR_FCTL:  reg_rdata = cfg.fctl;
      ADR_LSTAT: reg_rdata = {7'd0, cfg.ovr};
      default:   reg_rdata = '0;
    endcase
  end

  // R8
  tx_withdraw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == ADR_CTRL) && !reg_wdata[7]) |=> !irq_tx);

  // R8
  err_withdraw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == ADR_CTRL) && !reg_wdata[6] && !reg_wdata[3])
      |=> (!irq_err && !irq_brk));

  // R11
  loop_idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == ADR_FCTL) && reg_wdata[0]) |=> line_tx_out);
endmodule

// File: tb/serial_ctrl_regs_tb.sv
`timescale 1ns/1ps
module serial_ctrl_regs_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] ev = '0;
  logic tx_ser_in = 1'b0, ext_rx_in = 1'b1;
  logic [7:0] reg_rdata;
  logic tx_fifo_clr, rx_fifo_clr, tx_en, rx_en, ext_clk_en, modem_ctl_en;
  logic [3:0] frame_fmt;
  logic frame_tick, line_tx_out, rx_ser_out, irq_tx, irq_rx, irq_err, irq_brk;

  always #5 clk = ~clk;

  serial_ctrl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_rx_ready(ev[0]), .ev_rx_full(ev[1]), .ev_parity_err(ev[2]),
    .ev_frame_err(ev[3]), .ev_break(ev[4]), .ev_tx_empty(ev[5]),
    .ev_tx_end(ev[6]), .ev_overrun(ev[7]),
    .tx_fifo_clr(tx_fifo_clr), .rx_fifo_clr(rx_fifo_clr), .tx_en(tx_en),
    .rx_en(rx_en), .ext_clk_en(ext_clk_en), .modem_ctl_en(modem_ctl_en),
    .frame_fmt(frame_fmt), .frame_tick(frame_tick), .tx_ser_in(tx_ser_in),
    .ext_rx_in(ext_rx_in), .line_tx_out(line_tx_out), .rx_ser_out(rx_ser_out),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err), .irq_brk(irq_brk)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_mode = 0, m_rate = 0, m_ctrl = 0, m_stat = 'h60, m_fctl = 0, m_ovr = 0;
  int m_txclr = 0, m_rxclr = 0, m_cnt = 0;

  function automatic int period();
    return 320 * (1 << (2 * (m_mode & 3))) * (m_rate + 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_rate = 0; m_ctrl = 0; m_stat = 'h60; m_fctl = 0; m_ovr = 0;
      m_txclr = 0; m_rxclr = 0; m_cnt = 0;
    end else begin
      automatic int p = period();
      automatic bit run = ((m_ctrl >> 4) & 3) != 0;
      automatic bit rs = reg_wr && (reg_addr == 0 || reg_addr == 1);
      automatic bit fw = reg_wr && reg_addr == 4;
      if (rs || !run) m_cnt = 0;
      else m_cnt = (m_cnt + 1 == p) ? 0 : m_cnt + 1;
      if (reg_wr && reg_addr == 3) m_stat = m_stat & reg_wdata;
      if (ev[0]) m_stat |= 'h01;
      if (ev[1]) m_stat |= 'h02;
      if (ev[2]) m_stat |= 'h84;
      if (ev[3]) m_stat |= 'h88;
      if (ev[4]) m_stat |= 'h10;
      if (ev[5]) m_stat |= 'h20;
      if (ev[6]) m_stat |= 'h40;
      if (fw && reg_wdata[2]) m_stat |= 'h60;
      if (fw && reg_wdata[1]) m_stat &= ~'h03;
      if (reg_wr && reg_addr == 5 && !reg_wdata[0]) m_ovr = 0;
      if (ev[7]) m_ovr = 1;
      m_txclr = fw && reg_wdata[2];
      m_rxclr = fw && reg_wdata[1];
      if (reg_wr && reg_addr == 0) m_mode = reg_wdata & 'h7B;
      if (reg_wr && reg_addr == 1) m_rate = reg_wdata;
      if (reg_wr && reg_addr == 2) m_ctrl = reg_wdata & 'hFA;
      if (fw) m_fctl = reg_wdata & 'h09;
    end
  end

  int cyc = 0, last_tick = -1, tick_gap = 0, tick_cnt = 0;

  always @(posedge clk) begin
    #2;
    cyc++;
    if (rst_n && !done) begin
      automatic bit eie = ((m_ctrl >> 6) & 1) || ((m_ctrl >> 3) & 1);
      automatic int e_tx = ((m_ctrl >> 7) & 1) & ((m_stat >> 5) & 1);
      automatic int e_rx = ((m_ctrl >> 6) & 1) & ((m_stat & 3) != 0);
      automatic int e_er = eie & ((((m_stat >> 7) & 1) | m_ovr) != 0);
      automatic int e_bk = eie & ((m_stat >> 4) & 1);
      automatic bit lp = m_fctl & 1;
      automatic int e_tk = (((m_ctrl >> 4) & 3) != 0) && (m_cnt == period() - 1);
      chk(irq_tx == e_tx, "R6 irq_tx", irq_tx, e_tx);
      chk(irq_rx == e_rx, "R6 irq_rx", irq_rx, e_rx);
      chk(irq_err == e_er, "R7 irq_err", irq_err, e_er);
      chk(irq_brk == e_bk, "R7 irq_brk", irq_brk, e_bk);
      chk(tx_fifo_clr == m_txclr && rx_fifo_clr == m_rxclr, "R9 clr pulses",
          {tx_fifo_clr, rx_fifo_clr}, {m_txclr[0], m_rxclr[0]});
      chk(line_tx_out == (lp ? 1'b1 : tx_ser_in) &&
          rx_ser_out == (lp ? tx_ser_in : ext_rx_in), "R11 routing",
          {line_tx_out, rx_ser_out}, {(lp ? 1'b1 : tx_ser_in), (lp ? tx_ser_in : ext_rx_in)});
      chk(frame_tick == e_tk, "R12 tick", frame_tick, e_tk);
      if (frame_tick) begin
        if (last_tick >= 0) tick_gap = cyc - last_tick;
        last_tick = cyc;
        tick_cnt++;
      end
    end
  end

  task automatic drive(input bit w, input logic [2:0] a, input logic [7:0] d, input logic [7:0] e);
    @(negedge clk);
    reg_wr = w; reg_addr = a; reg_wdata = d; ev = e;
    @(negedge clk);
    reg_wr = 1'b0; ev = '0;
  endtask

  task automatic rd(input logic [2:0] a, input int exp, input string tag);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp[7:0], tag, reg_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    // R1 reset values, R13 unused addresses
    rd(0, 'h00, "R1 mode"); rd(1, 'h00, "R1 rate"); rd(2, 'h00, "R1 ctrl");
    rd(3, 'h60, "R1 stat"); rd(4, 'h00, "R1 fctl"); rd(5, 'h00, "R1 lstat");
    chk(!irq_tx && !irq_rx && !irq_err && !irq_brk, "R1 irqs", irq_tx, 0);
    rd(6, 'h00, "R13 addr6"); rd(7, 'h00, "R13 addr7");
    // R2 control mask and enables
    drive(1, 2, 'hFF, 0);
    rd(2, 'hFA, "R2 ctrl mask");
    chk(tx_en && rx_en && ext_clk_en, "R2 enables", {tx_en, rx_en, ext_clk_en}, 7);
    chk(irq_tx == 1, "R6 tx irq from reset flag", irq_tx, 1);
    // R3 mode mask and format
    drive(1, 0, 'hFF, 0);
    rd(0, 'h7B, "R3 mode mask");
    chk(frame_fmt == 4'hF, "R3 frame_fmt", frame_fmt, 'hF);
    drive(1, 0, 'h00, 0);
    chk(frame_fmt == 4'h0, "R3 frame_fmt clear", frame_fmt, 0);
    drive(1, 1, 'hA5, 0);
    rd(1, 'hA5, "R12 rate readback");
    // R4 write-zero-to-clear
    drive(1, 3, 'hFF, 0); rd(3, 'h60, "R4 write ones keeps");
    drive(1, 3, 'hDF, 0); rd(3, 'h40, "R4 clear bit5");
    chk(irq_tx == 0, "R6 tx irq drops", irq_tx, 0);
    drive(1, 3, 'h00, 0); rd(3, 'h00, "R4 clear all");
    drive(1, 3, 'hFF, 0); rd(3, 'h00, "R4 no sw set");
    // R6 receive request
    drive(0, 0, 0, 'h02); rd(3, 'h02, "R5 rx_full sets bit1");
    chk(irq_rx == 1, "R6 irq_rx", irq_rx, 1);
    // R5 collisions
    drive(1, 3, 'h00, 'h01); rd(3, 'h01, "R5 clear with ready event");
    drive(1, 3, 'h00, 'h02); rd(3, 'h02, "R5 event beats clear");
    drive(1, 3, 'h00, 0); rd(3, 'h00, "R4 cleared");
    // R7 / R8 error and break requests
    drive(0, 0, 0, 'h08); rd(3, 'h88, "R5 frame error bits");
    chk(irq_err == 1, "R7 irq_err rie", irq_err, 1);
    drive(1, 2, 'h08, 0);
    chk(irq_err == 1 && irq_rx == 0, "R7 irq_err via eie", {irq_err, irq_rx}, 2);
    drive(1, 2, 'h00, 0);
    chk(irq_err == 0, "R8 irq_err withdrawn", irq_err, 0);
    rd(3, 'h88, "R8 flags kept");
    drive(1, 2, 'h40, 0);
    chk(irq_err == 1, "R7 irq_err back", irq_err, 1);
    drive(0, 0, 0, 'h10); rd(3, 'h98, "R5 break bit");
    chk(irq_brk == 1, "R7 irq_brk", irq_brk, 1);
    drive(1, 2, 'h00, 0);
    chk(irq_brk == 0, "R8 irq_brk withdrawn", irq_brk, 0);
    drive(1, 2, 'h48, 0);
    drive(1, 3, 'h00, 0);
    drive(0, 0, 0, 'h04); rd(3, 'h84, "R5 parity bits");
    drive(1, 3, 'h00, 0);
    chk(irq_err == 0, "R7 irq_err idle", irq_err, 0);
    // R10 overrun
    drive(0, 0, 0, 'h80); rd(5, 'h01, "R10 overrun set");
    chk(irq_err == 1, "R7 overrun irq", irq_err, 1);
    drive(1, 5, 'hFF, 0); rd(5, 'h01, "R10 write one keeps");
    drive(1, 5, 'h00, 0); rd(5, 'h00, "R10 clear");
    chk(irq_err == 0, "R10 irq_err drops", irq_err, 0);
    drive(1, 5, 'h00, 'h80); rd(5, 'h01, "R10 event beats clear");
    drive(1, 5, 'h00, 0);
    // R9 FIFO control
    drive(1, 4, 'h06, 'h02);
    rd(3, 'h60, "R9 resets over rx event");
    chk(tx_fifo_clr && rx_fifo_clr, "R9 pulses high", {tx_fifo_clr, rx_fifo_clr}, 3);
    rd(4, 'h00, "R9 reset bits not stored");
    @(negedge clk);
    chk(!tx_fifo_clr && !rx_fifo_clr, "R9 pulses one cycle", {tx_fifo_clr, rx_fifo_clr}, 0);
    drive(1, 4, 'h0F, 0);
    rd(4, 'h09, "R9 fctl keep");
    chk(modem_ctl_en == 1, "R9 modem", modem_ctl_en, 1);
    // R11 loopback
    tx_ser_in = 0; ext_rx_in = 1; #1;
    chk(line_tx_out == 1 && rx_ser_out == 0, "R11 loop a", {line_tx_out, rx_ser_out}, 2);
    tx_ser_in = 1; ext_rx_in = 0; #1;
    chk(rx_ser_out == 1, "R11 loop b", rx_ser_out, 1);
    drive(1, 4, 'h00, 0);
    tx_ser_in = 0; ext_rx_in = 1; #1;
    chk(line_tx_out == 0 && rx_ser_out == 1, "R11 normal", {line_tx_out, rx_ser_out}, 1);
    // R12 frame tick
    drive(1, 2, 'h30, 0);
    drive(1, 0, 'h00, 0);
    drive(1, 1, 'h00, 0);
    last_tick = -1; tick_gap = 0;
    idle(700);
    chk(tick_gap == 320, "R12 period p1 r0", tick_gap, 320);
    drive(1, 0, 'h01, 0);
    drive(1, 1, 'h02, 0);
    last_tick = -1; tick_gap = 0;
    idle(8000);
    chk(tick_gap == 3840, "R12 period p4 r2", tick_gap, 3840);
    drive(1, 2, 'h00, 0);
    tick_cnt = 0;
    idle(4000);
    chk(tick_cnt == 0, "R12 held when disabled", tick_cnt, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule